// File: doc/BRIEF.md
# Serial NOR Flash Block-Protect Range Decoder

This block models the write-protect decision of a serial NOR flash. A request carries an 8-bit status byte, the base-2 logarithm of the device size, the base-2 logarithm of the sector count, three configuration straps and a write or erase address. The block decodes the block-protect code in the status byte into a protected region, given as a start offset and a length in bytes. It also reports whether the address lies inside that region. The status fields for sector-granular protection and for complemented ranges are taken as zero.

The protected size follows the sector count. The first nonzero code covers one sector, and each further code doubles the size. Codes past the last doubling cover the whole array. In the narrow 3-bit mode the code is instead mapped to a fixed fraction of the device. A strap selects the mode. Two further straps place the top/bottom flag and the fourth protect bit at status bit 5 or bit 6.

Requests use a valid/ready handshake and are handled by a two-state controller:
- **IDLE**: the block is ready for a request. The transition **accept** (request valid while in IDLE) registers the decoded result and moves to HOLD.
- **HOLD**: the result is valid. The transition **release** (response ready while in HOLD) returns to IDLE. While ready stays low, HOLD loops on itself and keeps the result unchanged.

Top module: `bp_range_decoder`

## Requirements
- R1: A protect code of zero gives offset 0, length 0 and hit 0.
- R2: In 3-bit mode (`mode4`=0) the code is status bits [4:2]. The length is size >> (7 − code). Status bits 7, 6, 1 and 0 do not change the length.
- R3: In 4-bit mode (`mode4`=1) the code is {BP3, status[4:2]}. For 1 ≤ code ≤ sector-log2, the length is one sector (size >> sector-log2) times 2^(code−1). Any larger code gives length = size.
- R4: BP3 is read from status bit 6 when `bp3_at6`=1 and from status bit 5 otherwise.
- R5: The top/bottom flag is read from status bit 6 when `tb_at6`=1 and from bit 5 otherwise. When the flag is 1 and the length is nonzero, the offset is 0.
- R6: When the top/bottom flag is 0 and the length is nonzero, the offset is size − length, so the region ends at the top of the device.
- R7: `prot_hit` is 1 exactly when length ≠ 0 and offset ≤ `addr` < offset + length.
- R8: `req_ready` is high only in IDLE. `rsp_valid` rises in the cycle after a request is accepted. All result outputs hold steady until `rsp_ready` is seen.
- R9: After reset the block is in IDLE with `rsp_valid` low and all result outputs zero.
- R10: For a 64 MiB device with 1024 sectors in 4-bit mode: code 1 gives 64 KiB, code 2 gives 128 KiB, code 9 gives 16 MiB, code 10 gives 32 MiB, and codes 11 and 12 give 64 MiB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (IDLE) |
| status | input | 8 | Status register value |
| size_log2 | input | LOG_W | log2 of device size in bytes |
| sect_log2 | input | LOG_W | log2 of sector count |
| mode4 | input | 1 | 1: 4-bit protect code, 0: 3-bit |
| tb_at6 | input | 1 | Top/bottom flag at status bit 6 (else bit 5) |
| bp3_at6 | input | 1 | BP3 at status bit 6 (else bit 5) |
| addr | input | ADDR_W | Write/erase address to test |
| rsp_valid | output | 1 | Result valid (HOLD) |
| rsp_ready | input | 1 | Consumer takes the result |
| prot_ofs | output | ADDR_W+1 | Protected region start offset |
| prot_len | output | ADDR_W+1 | Protected region length |
| prot_hit | output | 1 | Address lies in protected region |

## Verification
The embedded assertions check the handshake on every cycle:
- an accepted request yields a valid response on the next cycle;
- ready and valid are never high together;
- a stalled response does not change.

They also check two properties of every valid result: the region never extends past the device end, and a zero-length region never reports a hit.

Only the bench scenarios can show that each status byte maps to the right code, length and offset under each strap setting. The same goes for the sliding-sector saturation, the strap-controlled bit placement, and the exact address bounds of the hit. The bench shows these by sweeping all status values for every strap combination on two device geometries.

// File: rtl/bp_dec_pkg.sv
package bp_dec_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } dec_state_e;

    localparam int BP_LSB   = 2;
    localparam int BP_W3    = 3;
    localparam int CODE_W   = 4;
    localparam int FLAG_LO  = 5;
    localparam int FLAG_HI  = 6;
endpackage

// File: rtl/bp_code_extract.sv
module bp_code_extract
    import bp_dec_pkg::*;
(
    input  logic [7:0]        status,
    input  logic              mode4,
    input  logic              tb_at6,
    input  logic              bp3_at6,
    output logic [CODE_W-1:0] code,
    output logic              bottom
);
    logic [BP_W3-1:0] low_bits;
    logic             bp3;

    always_comb begin
        low_bits = status[BP_LSB +: BP_W3];
        bp3      = bp3_at6 ? status[FLAG_HI] : status[FLAG_LO];
        code     = mode4 ? {bp3, low_bits} : {1'b0, low_bits};
        bottom   = tb_at6 ? status[FLAG_HI] : status[FLAG_LO];
    end
endmodule

// File: rtl/bp_region_calc.sv
module bp_region_calc
    import bp_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LOG_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    input  logic              mode4,
    input  logic              bottom,
    input  logic [LOG_W-1:0]  size_log2,
    input  logic [LOG_W-1:0]  sect_log2,
    output logic [ADDR_W:0]   size_full,
    output logic [ADDR_W:0]   len,
    output logic [ADDR_W:0]   ofs
);
    localparam int OFS_W = ADDR_W + 1;
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    logic [LOG_W-1:0] code_ext;
    logic [LOG_W-1:0] pow;
    logic             saturate;

    always_comb begin
        size_full = ONE << size_log2;
        code_ext  = LOG_W'(code);
        saturate  = 1'b0;
        if (mode4) begin
            saturate = (code_ext > sect_log2);
            pow      = saturate ? '0 : (sect_log2 + LOG_W'(1) - code_ext);
        end else begin
            pow      = LOG_W'(code[BP_W3-1:0] ^ 3'b111);
        end
        if (code == '0) begin
            len = '0;
        end else begin
            len = size_full >> pow;
        end
        if (len == '0 || bottom) begin
            ofs = '0;
        end else begin
            ofs = size_full - len;
        end
    end
endmodule

// File: rtl/bp_range_cmp.sv
module bp_range_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   ofs,
    input  logic [ADDR_W:0]   len,
    output logic              hit
);
    logic [ADDR_W+1:0] lim;
    logic [ADDR_W+1:0] a_ext;
    logic [ADDR_W+1:0] o_ext;

    always_comb begin
        a_ext = {2'b00, addr};
        o_ext = {1'b0, ofs};
        lim   = o_ext + {1'b0, len};
        hit   = (len != '0) && (a_ext >= o_ext) && (a_ext < lim);
    end
endmodule

// File: rtl/bp_range_decoder.sv
module bp_range_decoder
    import bp_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LOG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        status,
    input  logic [LOG_W-1:0]  size_log2,
    input  logic [LOG_W-1:0]  sect_log2,
    input  logic              mode4,
    input  logic              tb_at6,
    input  logic              bp3_at6,
    input  logic [ADDR_W-1:0] addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W:0]   prot_ofs,
    output logic [ADDR_W:0]   prot_len,
    output logic              prot_hit
);
    dec_state_e state_q, state_d;

    logic [CODE_W-1:0] code_w;
    logic              bottom_w;
    logic [ADDR_W:0]   size_w, len_w, ofs_w;
    logic              hit_w;
    logic [ADDR_W:0]   size_q;
    logic              accept;

    bp_code_extract u_extract (
        .status  (status),
        .mode4   (mode4),
        .tb_at6  (tb_at6),
        .bp3_at6 (bp3_at6),
        .code    (code_w),
        .bottom  (bottom_w)
    );

    bp_region_calc #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_region (
        .code      (code_w),
        .mode4     (mode4),
        .bottom    (bottom_w),
        .size_log2 (size_log2),
        .sect_log2 (sect_log2),
        .size_full (size_w),
        .len       (len_w),
        .ofs       (ofs_w)
    );

    bp_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr (addr),
        .ofs  (ofs_w),
        .len  (len_w),
        .hit  (hit_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_HOLD;
            ST_HOLD: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_HOLD);
        accept    = req_ready && req_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_ofs <= '0;
            prot_len <= '0;
            prot_hit <= 1'b0;
            size_q   <= '0;
        end else if (accept) begin
            prot_ofs <= ofs_w;
            prot_len <= len_w;
            prot_hit <= hit_w;
            size_q   <= size_w;
        end
    end

    // R8
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R8
    no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(prot_ofs)
                                       && $stable(prot_len) && $stable(prot_hit)));

    // R7
    zero_len_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && prot_len == '0) |-> !prot_hit);

    // R6
    in_device_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (({1'b0, prot_ofs} + {1'b0, prot_len}) <= {1'b0, size_q}));
endmodule

// File: tb/bp_range_decoder_tb_top.sv
module bp_range_decoder_tb_top;
    localparam int ADDR_W = 32;
    localparam int LOG_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [7:0]        status = '0;
    logic [LOG_W-1:0]  size_log2 = '0;
    logic [LOG_W-1:0]  sect_log2 = '0;
    logic              mode4 = 1'b0;
    logic              tb_at6 = 1'b0;
    logic              bp3_at6 = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [ADDR_W:0]   prot_ofs;
    logic [ADDR_W:0]   prot_len;
    logic              prot_hit;

    int n_checks = 0;
    int n_fail   = 0;
    int n_req    = 0;

    always #10 clk = ~clk;

    bp_range_decoder #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .status(status), .size_log2(size_log2), .sect_log2(sect_log2),
        .mode4(mode4), .tb_at6(tb_at6), .bp3_at6(bp3_at6), .addr(addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .prot_ofs(prot_ofs), .prot_len(prot_len), .prot_hit(prot_hit)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input logic [7:0] st, input int slog, input int sclog,
                         input bit m4, input bit tb6, input bit b36,
                         output longint len, output longint ofs, output int code);
        longint size;
        bit tb;
        size = longint'(1) << slog;
        code = int'(st[4:2]);
        if (m4) code += (b36 ? int'(st[6]) : int'(st[5])) * 8;
        if (code == 0)          len = 0;
        else if (!m4)           len = size / (longint'(1) << (7 - code));
        else if (code > sclog)  len = size;
        else                    len = (size / (longint'(1) << sclog)) * (longint'(1) << (code - 1));
        tb  = tb6 ? st[6] : st[5];
        ofs = (len == 0 || tb) ? 0 : size - len;
    endtask

    task automatic run_one(input logic [7:0] st, input int slog, input int sclog,
                           input bit m4, input bit tb6, input bit b36,
                           input longint probe, input bit stall);
        longint elen, eofs;
        int     ecode;
        bit     ehit;
        string  ltag, otag;
        model(st, slog, sclog, m4, tb6, b36, elen, eofs, ecode);
        ehit = (elen != 0) && (probe >= eofs) && (probe < eofs + elen);
        @(negedge clk);
        check("R8 ready in idle", longint'(req_ready), 1);
        status = st; size_log2 = LOG_W'(slog); sect_log2 = LOG_W'(sclog);
        mode4 = m4; tb_at6 = tb6; bp3_at6 = b36; addr = ADDR_W'(probe);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 valid after accept", longint'(rsp_valid), 1);
        check("R8 not ready in hold", longint'(req_ready), 0);
        if (ecode == 0) ltag = "R1 zero code length";
        else if (m4)    ltag = "R3/R4 4-bit length";
        else            ltag = "R2 3-bit length";
        check(ltag, longint'(prot_len), elen);
        otag = ((tb6 ? st[6] : st[5]) == 1'b1) ? "R5 bottom offset" : "R6 top offset";
        check(otag, longint'(prot_ofs), eofs);
        check("R7 hit", longint'(prot_hit), longint'(ehit));
        if (stall) begin
            @(negedge clk);
            check("R8 held valid", longint'(rsp_valid), 1);
            check("R8 held len", longint'(prot_len), elen);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R8 released", longint'(rsp_valid), 0);
        n_req++;
    endtask

    task automatic sweep(input int slog, input int sclog);
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int s = 0; s < 256; s++) begin
                longint elen, eofs, probe;
                int ecode, k;
                model(8'(s), slog, sclog, cfg[0], cfg[1], cfg[2], elen, eofs, ecode);
                k = (s + cfg) % 5;
                case (k)
                    0: probe = (eofs > 0) ? eofs - 1 : 0;
                    1: probe = eofs;
                    2: probe = (elen > 0) ? eofs + elen - 1 : 3;
                    3: probe = eofs + elen;
                    default: probe = eofs + elen / 2;
                endcase
                if (probe >= (longint'(1) << slog)) probe = (longint'(1) << slog) - 1;
                run_one(8'(s), slog, sclog, cfg[0], cfg[1], cfg[2], probe, (s % 7) == 3);
            end
        end
    endtask

    task automatic ex_check(input int code, input longint exp_len);
        logic [7:0] st;
        st = {1'b0, 1'b0, code[3] ? 1'b1 : 1'b0, code[2:0], 2'b00};
        @(negedge clk);
        status = st; size_log2 = 6'd26; sect_log2 = 6'd10;
        mode4 = 1'b1; tb_at6 = 1'b1; bp3_at6 = 1'b0; addr = '0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 example length", longint'(prot_len), exp_len);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        #5000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", n_req);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", longint'(rsp_valid), 0);
        check("R9 reset ofs", longint'(prot_ofs), 0);
        check("R9 reset len", longint'(prot_len), 0);
        check("R9 reset hit", longint'(prot_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after reset", longint'(req_ready), 1);
        ex_check(1,  64'h1_0000);
        ex_check(2,  64'h2_0000);
        ex_check(9,  64'h100_0000);
        ex_check(10, 64'h200_0000);
        ex_check(11, 64'h400_0000);
        ex_check(12, 64'h400_0000);
        sweep(16, 4);
        sweep(26, 10);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule